// File: doc/BRIEF.md
# Staggered Frame Upload Sequencer

This block feeds a one-dimensional light-modulator array of 1088 gray-scale elements over a shared 64-bit bus. It stores whole frames of one-byte pixel levels in two banks. The host fills the bank that is not in use through a byte-addressed write port, then swaps the banks with a one-cycle commit.

Uploads do not run on their own. Each one begins when an external position trigger arrives, which tells the block that the scanning stage has reached the next exposure point. An upload is a single transaction. A one-cycle start strobe comes first. Then come 136 consecutive data beats, each carrying eight pixels. A one-cycle latch strobe comes last, and it makes the array show the new frame.

Each beat takes four pixels from the lower half of the frame and four from the upper half, and places them on the byte lanes in an interleaved order.

Top module: `frame_upload_seq`

## Requirements
- R1: After reset, `busy`, `start_pulse`, `bus_en`, `latch_pulse` and `overrun` are 0 and `bus_data` is all zeros. Bank 0 is the displayed (active) bank.
- R2: A `trig` sampled high while idle produces a one-cycle `start_pulse` in the next cycle. `busy` is high from that cycle onward.
- R3: `bus_en` is high for exactly 136 consecutive cycles, and the first of them directly follows `start_pulse`.
- R4: Pixels are numbered from 0. On beat k (k = 0..135), let a = 4k and b = 544 + 4k. Byte lane n occupies `bus_data[8n+7:8n]`. Lanes 0 to 7 carry pixels a+2, a, b+2, b, a+1, a+3, b+1 and b+3, in that order.
- R5: `latch_pulse` is high for one cycle, directly after the last beat. `busy` is low in the cycle after that.
- R6: Host writes go to the inactive bank and do not change what an upload sends. A `commit` makes the written bank the one that is uploaded.
- R7: An upload sends the bank that was active when its trigger was sampled, even if a `commit` occurs during the upload.
- R8: A `trig` sampled while busy starts no new upload and sets `overrun`. `overrun` stays set until `ovf_clr` is high, and a new overrun wins over a clear in the same cycle.
- R9: Writes with `wr_addr` of 1088 or more are discarded and change no pixel of either bank.
- R10: `bus_data` is all zeros in every cycle where `bus_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Pixel write strobe |
| wr_addr | input | 11 | Pixel index in the inactive bank |
| wr_data | input | 8 | Pixel gray level |
| commit | input | 1 | Swap active and inactive banks |
| trig | input | 1 | Stage position trigger |
| ovf_clr | input | 1 | Clear the overrun flag |
| bus_data | output | 64 | Eight packed pixel bytes |
| bus_en | output | 1 | Data beat valid (bus clock enable) |
| start_pulse | output | 1 | Upload start strobe |
| latch_pulse | output | 1 | Latch/display strobe |
| busy | output | 1 | Upload in progress |
| overrun | output | 1 | Sticky lost-trigger flag |

## Verification
The checker watches the strobe framing on every cycle. It checks that start is followed by a beat, that exactly 136 beats come before the latch, that the strobes never overlap, that busy drops after the latch, that a busy-time trigger sets the flag and the flag is sticky, and that the bus is quiet between beats.

Only the bench scenarios can show which pixel lands on which lane. The same holds for which bank an upload reads around writes and commits, and for discarded out-of-range writes. The bench shows these by comparing every beat against a model of both banks.

// File: rtl/frame_upload_seq.sv
module frame_upload_seq #(
  parameter int NPIX  = 1088,
  parameter int PW    = 8,
  parameter int LANES = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [$clog2(NPIX)-1:0]        wr_addr,
  input  logic [PW-1:0]                  wr_data,
  input  logic                           commit,
  input  logic                           trig,
  input  logic                           ovf_clr,
  output logic [PW*LANES-1:0]            bus_data,
  output logic                           bus_en,
  output logic                           start_pulse,
  output logic                           latch_pulse,
  output logic                           busy,
  output logic                           overrun
);
  localparam int AW    = $clog2(NPIX);
  localparam int BEATS = NPIX / LANES;
  localparam int HALF  = NPIX / 2;
  localparam int BW    = $clog2(BEATS);
  localparam int IW    = $clog2(2 * NPIX);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_LATCH} st_t;

  st_t           st;
  logic [BW-1:0] beat;
  logic          act, rd_bank;
  logic [PW-1:0] mem [2*NPIX];
  logic [IW-1:0] widx, rbase;

  assign widx  = (act ? IW'(0) : IW'(NPIX)) + IW'(wr_addr);
  assign rbase = rd_bank ? IW'(NPIX) : IW'(0);

  always_ff @(posedge clk)
    if (wr_en && ({1'b0, wr_addr} < (AW+1)'(NPIX)))
      mem[widx] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      beat    <= '0;
      act     <= 1'b0;
      rd_bank <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (commit) act <= ~act;
      if (trig && st != S_IDLE) overrun <= 1'b1;
      else if (ovf_clr)         overrun <= 1'b0;
      case (st)
        S_IDLE:  if (trig) begin st <= S_START; rd_bank <= act; end
        S_START: begin st <= S_DATA; beat <= '0; end
        S_DATA:  if (beat == BW'(BEATS-1)) st <= S_LATCH;
                 else beat <= beat + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign start_pulse = (st == S_START);
  assign bus_en      = (st == S_DATA);
  assign latch_pulse = (st == S_LATCH);
  assign busy        = (st != S_IDLE);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int HOFF = ((l / 2) % 2) * HALF;
    localparam int OFF  = (l < 4) ? ((l % 2) ? 0 : 2) : ((l % 2) ? 3 : 1);
    logic [IW-1:0] idx;
    assign idx = rbase + IW'(HOFF) + IW'({beat, 2'b00}) + IW'(OFF);
    assign bus_data[l*PW +: PW] = bus_en ? mem[idx] : '0;
  end
endmodule

// File: rtl/frame_upload_seq_chk.sv
module frame_upload_seq_chk #(
  parameter int BEATS = 136,
  parameter int DW    = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig,
  input logic          ovf_clr,
  input logic [DW-1:0] bus_data,
  input logic          bus_en,
  input logic          start_pulse,
  input logic          latch_pulse,
  input logic          busy,
  input logic          overrun
);
  logic [15:0] cnt;
  always_ff @(posedge clk)
    if (!rst_n || start_pulse) cnt <= '0;
    else if (bus_en)           cnt <= cnt + 1'b1;

  p_start_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(!busy));
  p_start_then_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> bus_en);
  p_beat_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pulse |-> cnt == 16'(BEATS));
  p_strobes_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, bus_en, latch_pulse}));
  p_latch_after_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pulse |-> $past(bus_en));
  p_idle_after_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pulse |=> !busy);
  p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && busy) |=> overrun);
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovf_clr) |=> overrun);
  p_quiet_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |-> bus_data == '0);
endmodule

bind frame_upload_seq frame_upload_seq_chk #(.BEATS(NPIX/LANES), .DW(PW*LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .ovf_clr(ovf_clr), .bus_data(bus_data),
  .bus_en(bus_en), .start_pulse(start_pulse), .latch_pulse(latch_pulse),
  .busy(busy), .overrun(overrun));

// File: tb/sim_frame_upload_seq.sv
module sim_frame_upload_seq;
  localparam int CLK_P = 10;
  localparam int NPIX  = 1088;

  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, commit = 0, trig = 0, ovf_clr = 0;
  logic [10:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [63:0] bus_data;
  logic        bus_en, start_pulse, latch_pulse, busy, overrun;

  int errors = 0, checks = 0;
  logic [7:0] model [2][NPIX];
  int act_m = 0;

  always #(CLK_P/2) clk = ~clk;

  frame_upload_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .trig(trig), .ovf_clr(ovf_clr), .bus_data(bus_data),
    .bus_en(bus_en), .start_pulse(start_pulse), .latch_pulse(latch_pulse),
    .busy(busy), .overrun(overrun));

  task automatic chk(input bit ok, input string req, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  function automatic logic [63:0] exp_beat(input int bank, input int k);
    int a = 4*k, b = 544 + 4*k;
    int p[8];
    logic [63:0] v;
    p = '{a+2, a, b+2, b, a+1, a+3, b+1, b+3};
    for (int n = 0; n < 8; n++) v[8*n +: 8] = model[bank][p[n]];
    return v;
  endfunction

  task automatic write_px(input int addr, input logic [7:0] d);
    wr_en = 1; wr_addr = 11'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (addr < NPIX) model[1-act_m][addr] = d;
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < NPIX; i++) write_px(i, 8'((i*7 + seed*31 + (i >> 8)) & 255));
  endtask

  task automatic do_commit();
    commit = 1; @(negedge clk); commit = 0;
    act_m = 1 - act_m;
  endtask

  task automatic upload(input string tag, input int cm_beat, input int tr_beat);
    int eb = act_m;
    int bad = 0;
    trig = 1; @(negedge clk); trig = 0;
    chk(start_pulse && busy && !bus_en, {"R2 start ", tag}, {start_pulse, busy, bus_en}, 3'b110);
    chk(bus_data == 0, {"R10 quiet at start ", tag}, bus_data, 0);
    for (int k = 0; k < 136; k++) begin
      @(negedge clk);
      commit = 0; trig = 0;
      chk(bus_en && !start_pulse && !latch_pulse, {"R3 beat valid ", tag}, {bus_en, start_pulse, latch_pulse}, 3'b100);
      chk(bus_data == exp_beat(eb, k), {"R4/R6/R7 lane data ", tag}, bus_data, exp_beat(eb, k));
      if (k == cm_beat) begin commit = 1; act_m = 1 - act_m; end
      if (k == tr_beat) trig = 1;
    end
    @(negedge clk);
    commit = 0; trig = 0;
    chk(latch_pulse && !bus_en && busy, {"R5 latch ", tag}, {latch_pulse, bus_en, busy}, 3'b101);
    chk(bus_data == 0, {"R10 quiet at latch ", tag}, bus_data, 0);
    @(negedge clk);
    chk(!busy && !latch_pulse, {"R5 idle after ", tag}, {busy, latch_pulse}, 2'b00);
    if (bad != 0) errors += 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !start_pulse && !bus_en && !latch_pulse && !overrun, "R1 reset strobes",
        {busy, start_pulse, bus_en, latch_pulse, overrun}, 0);
    chk(bus_data == 0, "R1 reset bus", bus_data, 0);
  endtask

  task automatic t_basic();
    fill(1); do_commit();
    upload("basic", -1, -1);
  endtask

  task automatic t_double_buffer();
    fill(2);
    upload("R6 before commit", -1, -1);
    do_commit();
    upload("R6 after commit", -1, -1);
  endtask

  task automatic t_commit_mid();
    fill(3);
    upload("R7 commit mid", 10, -1);
    upload("R7 next upload", -1, -1);
  endtask

  task automatic t_overrun();
    upload("R8 trig mid", -1, 50);
    chk(overrun, "R8 overrun set", overrun, 1);
    repeat (5) begin
      @(negedge clk);
      chk(!busy && overrun, "R8 no restart, sticky", {busy, overrun}, 2'b01);
    end
    ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    chk(!overrun, "R8 cleared", overrun, 0);
  endtask

  task automatic t_bad_addr();
    write_px(1088, 8'hA5);
    write_px(1100, 8'h5A);
    write_px(2047, 8'h3C);
    upload("R9 out-of-range write", -1, -1);
    do_commit();
    upload("R9 other bank", -1, -1);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_double_buffer();
    t_commit_mid();
    t_overrun();
    t_bad_addr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule